// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block is a watchdog counter paced by a 16 Hz tick strobe. Software arms it through one 8-bit control register holding a 5-bit multiplier, a 2-bit resolution and a steering bit. The armed interval is the multiplier times four raised to the resolution, counted in ticks (sixteenths of a second). Any access to the control register, read or write, restarts the interval, so periodic reads act as the keep-alive.

When the interval runs out, a timeout flag is raised in a read-only status register. The steering bit chooses the consequence. If it is set, the block emits a one-cycle system reset request and a one-cycle pulse that clears the century flag held in the neighbouring calendar register, and it zeroes its own control register. If it is clear, the block emits a single one-cycle interrupt pulse and then stays idle until software restarts it.

Top module: `wdog_steer`

## Requirements
- R1: The control byte is decoded as resolution = bits 1:0, multiplier = bits 6:2, steering = bit 7. The expiry action fires on exactly the Nth tick after a restart, where N = multiplier * 4^resolution.
- R2: A write with `bus_sel_i`=0 stores the byte in the control register. It reads back unchanged with `bus_sel_i`=0 and restarts the interval.
- R3: A read with `bus_sel_i`=0 restarts the interval from the stored control value.
- R4: Every restart clears the timeout flag. The status register is read with `bus_sel_i`=1; its timeout flag is bit 7 and all other bits read 0.
- R5: Expiry sets status bit 7.
- R6: Expiry with steering = 1 gives a one-cycle `rst_req_o` and a one-cycle `century_clr_o` and no interrupt. It also clears the control register to 0x00.
- R7: Expiry with steering = 0 gives exactly one one-cycle `irq_o` and no reset request. The control register keeps its value and no further expiry occurs until the next restart.
- R8: A control value of zero, or any value whose multiplier is zero, leaves the timer disarmed, and no expiry occurs.
- R9: Writes with `bus_sel_i`=1 change neither the status register nor the control register.
- R10: A restart in the same cycle as the final tick takes priority. That tick is not counted, no expiry occurs, and a full new interval begins.
- R11: Synchronous reset clears the control register, the count, the timeout flag and all pulse outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_16hz_i | input | 1 | One-cycle strobe at 16 Hz |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_sel_i | input | 1 | 0 = control register, 1 = status register |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the selected register |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | One-cycle interrupt pulse |
| century_clr_o | output | 1 | One-cycle request to clear the calendar century flag |

## Verification
A restart (a control-register read or write) and the tick that would end the interval can land in the same clock cycle. The bench arms a three-tick interval and lets two ticks pass. It then asserts a control read together with the third tick in a single cycle. This is judged correct only if no pulse appears, the status flag stays clear, and exactly three further ticks are needed before the interrupt arrives.

// File: rtl/wdog_steer_pkg.sv
package wdog_steer_pkg;

   // Outcome of a count step at the end of an interval
   typedef enum logic [1:0] {
      WD_ACT_NONE  = 2'd0,
      WD_ACT_IRQ   = 2'd1,
      WD_ACT_RESET = 2'd2
   } wd_action_e;

   function automatic wd_action_e wd_pick_action(input logic fire, input logic steer);
      if (!fire)
         return WD_ACT_NONE;
      return steer ? WD_ACT_RESET : WD_ACT_IRQ;
   endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic              sel_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              clear_i,
   input  logic              flag_i,
   output logic [DATA_W-1:0] value_o,
   output logic [DATA_W-1:0] arm_value_o,
   output logic              restart_o,
   output logic [DATA_W-1:0] rdata_o
);

   logic [DATA_W-1:0] value_q;
   logic              ctl_wr;
   logic              ctl_rd;

   assign ctl_wr    = wr_i && !sel_i;
   assign ctl_rd    = rd_i && !sel_i;
   assign restart_o = ctl_wr || ctl_rd;

   // a write arms with the new byte, a read re-arms with the stored one
   assign arm_value_o = ctl_wr ? wdata_i : value_q;

   always_ff @(posedge clk) begin
      if (rst)
         value_q <= '0;
      else if (ctl_wr)
         value_q <= wdata_i;
      else if (clear_i)
         value_q <= '0;
   end

   assign value_o = value_q;
   assign rdata_o = sel_i ? {flag_i, {(DATA_W-1){1'b0}}} : value_q;

endmodule

// File: rtl/wdog_span.sv
module wdog_span #(
   parameter int MULT_W = 5,
   parameter int RES_W  = 2,
   parameter int CNT_W  = 11
) (
   input  logic [MULT_W-1:0] mult_i,
   input  logic [RES_W-1:0]  res_i,
   output logic [CNT_W-1:0]  span_o
);

   localparam int NRES = 2 ** RES_W;

   logic [CNT_W-1:0] spans [NRES];

   // one shifted copy per resolution step, each step a factor of four
   for (genvar r = 0; r < NRES; r++) begin : g_res
      assign spans[r] = CNT_W'(mult_i) << (2 * r);
   end

   assign span_o = spans[res_i];

endmodule

// File: rtl/wdog_count.sv
module wdog_count
   import wdog_steer_pkg::*;
#(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             restart_i,
   input  logic [CNT_W-1:0] span_i,
   input  logic             tick_i,
   input  logic             steer_i,
   output logic             fire_reset_o,
   output logic             flag_o,
   output logic             rst_pulse_o,
   output logic             irq_pulse_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;
   logic             flag_q;
   logic             rst_q;
   logic             irq_q;
   logic             last_tick;
   wd_action_e       act;

   assign last_tick    = !restart_i && armed_q && tick_i && (cnt_q == CNT_W'(1));
   assign act          = wd_pick_action(last_tick, steer_i);
   assign fire_reset_o = (act == WD_ACT_RESET);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
         flag_q  <= 1'b0;
         rst_q   <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         rst_q <= (act == WD_ACT_RESET);
         irq_q <= (act == WD_ACT_IRQ);
         if (restart_i) begin
            cnt_q   <= span_i;
            armed_q <= (span_i != '0);
            flag_q  <= 1'b0;
         end else if (last_tick) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            flag_q  <= 1'b1;
         end else if (armed_q && tick_i) begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   end

   assign flag_o      = flag_q;
   assign rst_pulse_o = rst_q;
   assign irq_pulse_o = irq_q;

endmodule

// File: rtl/wdog_steer.sv
module wdog_steer #(
   parameter int DATA_W = 8,
   parameter int MULT_W = 5,
   parameter int RES_W  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_16hz_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic              bus_sel_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              rst_req_o,
   output logic              irq_o,
   output logic              century_clr_o
);

   localparam int MAX_RES = 2 ** RES_W - 1;
   localparam int CNT_W   = MULT_W + 2 * MAX_RES;
   localparam int STEER_B = DATA_W - 1;

   if (DATA_W != MULT_W + RES_W + 1) begin : g_bad_layout
      $error("control byte must hold multiplier, resolution and steering bit exactly");
   end
   if (MULT_W < 1 || RES_W < 1) begin : g_bad_fields
      $error("multiplier and resolution fields need at least one bit");
   end

   logic [DATA_W-1:0] wd_value;
   logic [DATA_W-1:0] arm_value;
   logic              restart;
   logic              fire_reset;
   logic              flag;
   logic              rst_pulse;
   logic [CNT_W-1:0]  span;

   wdog_regs #(.DATA_W(DATA_W)) u_regs (
      .clk         (clk),
      .rst         (rst),
      .wr_i        (bus_wr_i),
      .rd_i        (bus_rd_i),
      .sel_i       (bus_sel_i),
      .wdata_i     (bus_wdata_i),
      .clear_i     (fire_reset),
      .flag_i      (flag),
      .value_o     (wd_value),
      .arm_value_o (arm_value),
      .restart_o   (restart),
      .rdata_o     (bus_rdata_o)
   );

   wdog_span #(.MULT_W(MULT_W), .RES_W(RES_W), .CNT_W(CNT_W)) u_span (
      .mult_i (arm_value[RES_W +: MULT_W]),
      .res_i  (arm_value[RES_W-1:0]),
      .span_o (span)
   );

   wdog_count #(.CNT_W(CNT_W)) u_count (
      .clk          (clk),
      .rst          (rst),
      .restart_i    (restart),
      .span_i       (span),
      .tick_i       (tick_16hz_i),
      .steer_i      (wd_value[STEER_B]),
      .fire_reset_o (fire_reset),
      .flag_o       (flag),
      .rst_pulse_o  (rst_pulse),
      .irq_pulse_o  (irq_o)
   );

   assign rst_req_o     = rst_pulse;
   assign century_clr_o = rst_pulse;

endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              restart,
   input logic              flag,
   input logic              rst_req,
   input logic              irq,
   input logic [DATA_W-1:0] wd_value
);

   p_flag_on_expiry_r5: assert property (@(posedge clk) disable iff (rst)
      (rst_req || irq) |-> flag);

   p_restart_clears_flag_r4: assert property (@(posedge clk) disable iff (rst)
      restart |=> !flag);

   p_reset_single_r6: assert property (@(posedge clk) disable iff (rst)
      rst_req |=> !rst_req);

   p_reset_clears_reg_r6: assert property (@(posedge clk) disable iff (rst)
      rst_req |-> (wd_value == '0));

   p_irq_single_r7: assert property (@(posedge clk) disable iff (rst)
      irq |=> !irq);

   p_irq_keeps_reg_r7: assert property (@(posedge clk) disable iff (rst)
      irq |-> (wd_value != '0 && !wd_value[DATA_W-1]));

   p_one_action_r7: assert property (@(posedge clk) disable iff (rst)
      !(rst_req && irq));

endmodule

bind wdog_steer wdog_steer_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .restart  (restart),
   .flag     (flag),
   .rst_req  (rst_req_o),
   .irq      (irq_o),
   .wd_value (wd_value)
);

// File: tb/wdog_steer_tb_top.sv
module wdog_steer_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick = 1'b0;
   logic       wr = 1'b0;
   logic       rd = 1'b0;
   logic       sel = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       rst_req;
   logic       irq;
   logic       cen;

   int total = 0;
   int bad = 0;
   int n_rst = 0;
   int n_irq = 0;
   int n_cen = 0;

   always #5 clk = ~clk;

   wdog_steer dut_i (
      .clk           (clk),
      .rst           (rst),
      .tick_16hz_i   (tick),
      .bus_wr_i      (wr),
      .bus_rd_i      (rd),
      .bus_sel_i     (sel),
      .bus_wdata_i   (wdata),
      .bus_rdata_o   (rdata),
      .rst_req_o     (rst_req),
      .irq_o         (irq),
      .century_clr_o (cen)
   );

   // count high cycles of each pulse output
   always @(negedge clk) begin
      if (rst_req) n_rst++;
      if (irq)     n_irq++;
      if (cen)     n_cen++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic s, input logic [7:0] d);
      @(negedge clk);
      wr = 1'b1; sel = s; wdata = d;
      @(negedge clk);
      wr = 1'b0; sel = 1'b0;
   endtask

   task automatic bus_read(input logic s, output logic [7:0] v);
      @(negedge clk);
      rd = 1'b1; sel = s;
      #1 v = rdata;
      @(negedge clk);
      rd = 1'b0; sel = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic quiet();
      repeat (3) @(negedge clk);
      #1;
   endtask

   // arm with v, check no action after n-1 ticks and one irq after n
   task automatic interval_case(input logic [7:0] v, input int n, input string req);
      int b;
      bus_write(1'b0, v);
      b = n_irq;
      ticks(n - 1);
      quiet();
      chk(n_irq == b, req, n_irq - b, 0);
      ticks(1);
      quiet();
      chk(n_irq == b + 1, req, n_irq - b, 1);
   endtask

   task automatic t_reset_state();
      logic [7:0] v;
      quiet();
      chk(!rst_req && !irq && !cen, "R11", {rst_req, irq, cen}, 0);
      bus_read(1'b0, v);
      chk(v == 8'h00, "R11", v, 8'h00);
      bus_read(1'b1, v);
      chk(v == 8'h00, "R11", v, 8'h00);
   endtask

   task automatic t_irq_steer();
      logic [7:0] v;
      int bi, br;
      bus_write(1'b0, 8'h0C);
      bus_read(1'b0, v);
      chk(v == 8'h0C, "R2", v, 8'h0C);
      bi = n_irq; br = n_rst;
      ticks(2);
      quiet();
      chk(n_irq == bi, "R1", n_irq - bi, 0);
      ticks(1);
      quiet();
      chk(n_irq == bi + 1, "R1", n_irq - bi, 1);
      chk(n_rst == br, "R7", n_rst - br, 0);
      bus_read(1'b1, v);
      chk(v == 8'h80, "R5", v, 8'h80);
      ticks(6);
      quiet();
      chk(n_irq == bi + 1, "R7", n_irq - bi, 1);
      bus_read(1'b0, v);
      chk(v == 8'h0C, "R7", v, 8'h0C);
      bus_read(1'b1, v);
      chk(v == 8'h00, "R4", v, 8'h00);
   endtask

   task automatic t_resolutions();
      interval_case(8'h09, 8, "R1");
      interval_case(8'h06, 16, "R1");
      interval_case(8'h07, 64, "R1");
   endtask

   task automatic t_reset_steer();
      logic [7:0] v;
      int bi, br, bc;
      bus_write(1'b0, 8'h88);
      bi = n_irq; br = n_rst; bc = n_cen;
      ticks(1);
      quiet();
      chk(n_rst == br, "R6", n_rst - br, 0);
      ticks(1);
      quiet();
      chk(n_rst == br + 1, "R6", n_rst - br, 1);
      chk(n_cen == bc + 1, "R6", n_cen - bc, 1);
      chk(n_irq == bi, "R6", n_irq - bi, 0);
      bus_read(1'b1, v);
      chk(v == 8'h80, "R5", v, 8'h80);
      bus_read(1'b0, v);
      chk(v == 8'h00, "R6", v, 8'h00);
      ticks(10);
      quiet();
      chk(n_rst == br + 1, "R6", n_rst - br, 1);
   endtask

   task automatic t_read_restart();
      int b;
      logic [7:0] v;
      bus_write(1'b0, 8'h10);
      b = n_irq;
      ticks(3);
      bus_read(1'b0, v);
      ticks(3);
      quiet();
      chk(n_irq == b, "R3", n_irq - b, 0);
      ticks(1);
      quiet();
      chk(n_irq == b + 1, "R3", n_irq - b, 1);
   endtask

   task automatic t_flags_ro();
      logic [7:0] v;
      bus_write(1'b0, 8'h08);
      ticks(2);
      quiet();
      bus_write(1'b1, 8'h00);
      bus_read(1'b1, v);
      chk(v == 8'h80, "R9", v, 8'h80);
      bus_write(1'b1, 8'h7F);
      bus_read(1'b1, v);
      chk(v == 8'h80, "R9", v, 8'h80);
      bus_read(1'b0, v);
      chk(v == 8'h08, "R9", v, 8'h08);
   endtask

   task automatic t_disabled();
      logic [7:0] v;
      int b;
      b = n_irq + n_rst;
      bus_write(1'b0, 8'h00);
      ticks(40);
      quiet();
      chk(n_irq + n_rst == b, "R8", n_irq + n_rst - b, 0);
      bus_write(1'b0, 8'h03);
      ticks(10);
      quiet();
      chk(n_irq + n_rst == b, "R8", n_irq + n_rst - b, 0);
      bus_read(1'b1, v);
      chk(v == 8'h00, "R8", v, 8'h00);
   endtask

   task automatic t_collision();
      logic [7:0] v;
      int b;
      bus_write(1'b0, 8'h0C);
      b = n_irq;
      ticks(2);
      @(negedge clk);
      tick = 1'b1; rd = 1'b1; sel = 1'b0;
      @(negedge clk);
      tick = 1'b0; rd = 1'b0;
      quiet();
      chk(n_irq == b, "R10", n_irq - b, 0);
      bus_read(1'b1, v);
      chk(v == 8'h00, "R10", v, 8'h00);
      ticks(2);
      quiet();
      chk(n_irq == b, "R10", n_irq - b, 0);
      ticks(1);
      quiet();
      chk(n_irq == b + 1, "R10", n_irq - b, 1);
   endtask

   task automatic t_sync_reset();
      logic [7:0] v;
      int br;
      bus_write(1'b0, 8'h88);
      br = n_rst;
      ticks(1);
      @(negedge clk); rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      ticks(5);
      quiet();
      chk(n_rst == br, "R11", n_rst - br, 0);
      bus_read(1'b1, v);
      chk(v == 8'h00, "R11", v, 8'h00);
      bus_read(1'b0, v);
      chk(v == 8'h00, "R11", v, 8'h00);
   endtask

   initial begin : watchdog
      #1000000;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset_state();
      t_irq_steer();
      t_resolutions();
      t_reset_steer();
      t_read_restart();
      t_flags_ro();
      t_disabled();
      t_collision();
      t_sync_reset();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule